// File: doc/BRIEF.md
# Next-Address Microprogram Sequencer

This block steps through a small read-only control store in which every word carries two fields: the address of the word that follows it, and a group of control signals. An address register reloads from the successor field of the word it currently points at on every clock, so the store does not have to be read in ascending order. One store image can hold several separate looping sequences, each with arbitrary jumps, and the sequence that runs depends only on the address the register starts from.

A load port forces an external start address into the register, and the start address selects the stored sequence to run. The control field of the addressed word is presented combinationally on the output. A build-time mode parameter swaps the successor field for a plain wrapping incrementer. This simpler variant is kept for comparison: in that variant every word is visited in ascending order.

The preloaded image holds a five-word loop starting at 0, a three-word loop starting at 5 and a four-word jumping chain starting at 8. Every other location simply falls through to the next address.

Top module: `micro_seq`

## Requirements
- R1: While reset is low, and right after it is released, `curAddr` is 0 and `ctrlOut` shows the control field of location 0.
- R2: Each store word is `{successor[ADDR_W-1:0], control[CTRL_W-1:0]}`, with the control field in the low bits. `ctrlOut` equals the control field of the word at `curAddr` in the same cycle, so it changes in the cycle after the address register is clocked.
- R3: In successor mode (`COUNT_MODE=0`), when `startLoad` is low, each rising clock loads `curAddr` with the successor field of the word at the old `curAddr`.
- R4: When `startLoad` is high at a rising clock, `curAddr` takes `startAddr`, and this overrides the successor field or the increment.
- R5: Starting from address 0, successor mode visits 0,1,2,3,4 and then returns to 0, repeating indefinitely.
- R6: Starting from address 5, successor mode visits 5,6,7 and then returns to 5.
- R7: Starting from address 8, successor mode visits 8, 10, 19, 26 and then returns to 8. At those four locations the control field values are 9, 10, 3 and 10.
- R8: In counter mode (`COUNT_MODE=1`), when `startLoad` is low, each rising clock increments `curAddr` by one, and the address wraps from DEPTH-1 to 0.
- R9: Every location not named in R5 to R7 has successor (address+1) mod DEPTH. Every location not named in R7 has a control field equal to the bitwise inverse of its address, taken over CTRL_W bits. With the defaults, this control value is 63 minus the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startLoad | input | 1 | Force `startAddr` into the address register on the next clock |
| startAddr | input | ADDR_W | Entry address of the sequence to run |
| ctrlOut | output | CTRL_W | Control field of the current word |
| curAddr | output | ADDR_W | Current control-store address |

## Verification
The hardest case to reach from the ports is a load that arrives while a chain is partway through a jump. Here the successor field points somewhere else, so a wrong priority shows up only as a single stray address. To create it, the stimulus lets the jumping chain run to its middle words and then asserts `startLoad` with an address in another loop. It also raises `startLoad` for consecutive cycles and loads into fall-through locations near the top of the store. The location just below the top exercises wrap-around. A second instance built in counter mode sees the same load pattern, so both successor paths are compared against the reference on every clock.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef struct packed {
    logic takeStart;
    logic takeNext;
  } seqStrobe_t;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = 5,
  parameter int CTRL_W = 6,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = ADDR_W + CTRL_W
) (
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] nextField,
  output logic [CTRL_W-1:0] ctrlField
);

  function automatic logic [WORD_W-1:0] imageWord(input int loc);
    int succ;
    int ctl;
    succ = (loc + 1) % DEPTH;
    ctl  = ~loc;
    case (loc)
      4:  succ = 0;
      7:  succ = 5;
      8:  begin succ = 10; ctl = 9;  end
      10: begin succ = 19; ctl = 10; end
      19: begin succ = 26; ctl = 3;  end
      26: begin succ = 8;  ctl = 10; end
      default: ;
    endcase
    return {succ[ADDR_W-1:0], ctl[CTRL_W-1:0]};
  endfunction

  logic [WORD_W-1:0] romWord [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_image
    assign romWord[i] = imageWord(i);
  end

  assign nextField = romWord[rdAddr][WORD_W-1:CTRL_W];
  assign ctrlField = romWord[rdAddr][CTRL_W-1:0];

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic       startLoad,
  output seqStrobe_t strobe
);

  always_comb begin
    strobe.takeStart = startLoad;
    strobe.takeNext  = !startLoad;
  end

endmodule

// File: rtl/useq_datapath.sv
module useq_datapath
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter bit COUNT_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] nextField,
  output logic [ADDR_W-1:0] curAddr
);

  logic [ADDR_W-1:0] succAddr;
  logic              pastValid;

  if (COUNT_MODE) begin : g_count
    assign succAddr = curAddr + ADDR_W'(1);
  end else begin : g_next
    assign succAddr = nextField;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      if (strobe.takeStart)     curAddr <= startAddr;
      else if (strobe.takeNext) curAddr <= succAddr;
    end
  end

  assert_start_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strobe.takeStart)) |-> (curAddr == $past(startAddr)));

  if (COUNT_MODE) begin : g_chk_count
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && !$past(strobe.takeStart)) |-> (curAddr == $past(curAddr) + ADDR_W'(1)));
  end else begin : g_chk_next
    assert_follow_next_R3: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && !$past(strobe.takeStart)) |-> (curAddr == $past(nextField)));
  end

endmodule

// File: rtl/micro_seq.sv
module micro_seq
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int CTRL_W     = 6,
  parameter bit COUNT_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startLoad,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic [ADDR_W-1:0] curAddr
);

  seqStrobe_t        strobe;
  logic [ADDR_W-1:0] nextField;

  useq_ctrl u_ctrl (
    .startLoad (startLoad),
    .strobe    (strobe)
  );

  useq_datapath #(.ADDR_W(ADDR_W), .COUNT_MODE(COUNT_MODE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startAddr (startAddr),
    .nextField (nextField),
    .curAddr   (curAddr)
  );

  useq_store #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_store (
    .rdAddr    (curAddr),
    .nextField (nextField),
    .ctrlField (ctrlOut)
  );

  assert_ctrl_tracks_R2: assert property (@(posedge clk) disable iff (!rstN)
    $stable(curAddr) |-> $stable(ctrlOut));

  assert_reset_zero_R1: assert property (@(posedge clk)
    (rstN === 1'b0) |-> (curAddr == '0));

endmodule

// File: tb/sim_micro_seq.sv
module sim_micro_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startLoad = 1'b0;
  logic [4:0] startAddr = '0;
  logic [5:0] ctrlOut, ctrlOutC;
  logic [4:0] curAddr, curAddrC;

  int total = 0;
  int bad = 0;
  int refA = 0;
  int refC = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  micro_seq #(.ADDR_W(5), .CTRL_W(6), .COUNT_MODE(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .startAddr(startAddr),
    .ctrlOut(ctrlOut), .curAddr(curAddr));

  micro_seq #(.ADDR_W(5), .CTRL_W(6), .COUNT_MODE(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .startAddr(startAddr),
    .ctrlOut(ctrlOutC), .curAddr(curAddrC));

  function automatic int refNext(int a);
    if (a == 4)  return 0;
    if (a == 7)  return 5;
    if (a == 8)  return 10;
    if (a == 10) return 19;
    if (a == 19) return 26;
    if (a == 26) return 8;
    return (a + 1) % 32;
  endfunction

  function automatic int refCtrl(int a);
    if (a == 8)  return 9;
    if (a == 10) return 10;
    if (a == 19) return 3;
    if (a == 26) return 10;
    return 63 - a;
  endfunction

  task automatic checkVal(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compareAll();
    checkVal(tag, curAddr, refA);
    checkVal("R2", ctrlOut, refCtrl(refA));
    checkVal("R8", curAddrC, refC);
    checkVal("R8 ctrl", ctrlOutC, refCtrl(refC));
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (startLoad) begin
      refA = startAddr;
      refC = startAddr;
    end else begin
      refA = refNext(refA);
      refC = (refC + 1) % 32;
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic loadAt(int a);
    startLoad = 1'b1;
    startAddr = 5'(a);
    tick();
    startLoad = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R1 rst addr", curAddr, 0);
    rstN = 1'b1;
    checkVal("R1 addr", curAddr, 0);
    checkVal("R1 ctrl", ctrlOut, 63);

    tag = "R5";
    for (int i = 1; i <= 12; i++) begin
      tick();
      checkVal("R5 loop", curAddr, i % 5);
    end

    tag = "R6";
    loadAt(5);
    checkVal("R4 load5", curAddr, 5);
    for (int i = 1; i <= 7; i++) begin
      tick();
      checkVal("R6 loop", curAddr, 5 + (i % 3));
    end

    tag = "R7";
    loadAt(8);
    begin
      int chainA[4] = '{8, 10, 19, 26};
      int chainC[4] = '{9, 10, 3, 10};
      for (int i = 0; i < 9; i++) begin
        checkVal("R7 addr", curAddr, chainA[i % 4]);
        checkVal("R7 ctrl", ctrlOut, chainC[i % 4]);
        tick();
      end
    end

    tag = "R4";
    loadAt(8);
    tick();
    loadAt(2);
    checkVal("R4 mid-chain", curAddr, 2);
    startLoad = 1'b1;
    startAddr = 5'd6;
    tick();
    startAddr = 5'd19;
    tick();
    checkVal("R4 back-to-back", curAddr, 19);
    startLoad = 1'b0;

    tag = "R9";
    loadAt(30);
    checkVal("R9 ctrl30", ctrlOut, 33);
    tick();
    checkVal("R9 wrap", curAddr, 31);
    tick();
    checkVal("R9 wrap0", curAddr, 0);
    loadAt(12);
    for (int i = 0; i < 6; i++) tick();
    checkVal("R9 fall", curAddr, 18);

    tag = "R8";
    loadAt(28);
    for (int i = 0; i < 40; i++) tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule